// File: doc/BRIEF.md
# Prescaled Timer/Counter Pair

This block holds two independent 16-bit up-counters. Each counter, called a unit, runs either as a timer or as an event counter. In timer mode a unit advances once per machine cycle. A machine cycle is twelve system clocks, produced by a shared free-running divider. In event mode a unit advances on a high-to-low transition of its own asynchronous count input. The count input passes through a two-flop synchroniser and is then sampled once per machine cycle. As a result, each input level must be held for at least one machine cycle, and a falling edge takes two samples to recognise.

Software reaches the block through a byte-wide register port. The port gives access to the low and high byte of each counter, and to one control byte holding run, mode and overflow-flag bits. When a counter wraps from all ones to zero, its flag is set, and the flag drives that unit's interrupt request. The flag is cleared by an interrupt acknowledge or by a software write to the control byte. Clearing a run bit freezes the counter at its present value.

Top module: `prescaled_timer_pair`

## Requirements
- R1: After reset, every readable register (addresses 0 to 4) reads 0x00 and both interrupt requests are low.
- R2: A unit in timer mode with its run bit set advances by exactly one on every twelfth clock edge. Run for exactly 12*N clocks, it gains N.
- R3: A unit in event mode with its run bit set advances by one for each high-to-low transition of its count input, provided each level is held for at least two machine cycles.
- R4: With its run bit clear, a unit keeps its value: neither elapsed time nor count-input transitions change it.
- R5: A wrap from 0xFFFF to 0x0000 sets the unit's overflow flag, and the unit's interrupt request follows the flag. The flags are control bit 5 for unit 0 and control bit 7 for unit 1. The interrupt requests are irqReq[0] and irqReq[1].
- R6: A one-cycle pulse on a unit's irqAck bit clears that unit's flag and interrupt request.
- R7: Writing the control byte loads the flag bits from the written data, so writing 0 to a flag bit clears it.
- R8: Register map: address 0 is the control byte; 1 and 2 are unit 0 low and high bytes; 3 and 4 are unit 1 low and high bytes. The control byte holds unit 0's mode in bit 2 and unit 1's mode in bit 3 (1 selects event mode). It holds unit 0's run bit in bit 4 and unit 1's run bit in bit 6. Every byte written reads back unchanged.
- R9: A write to either byte of a counter takes priority over an increment of that counter in the same clock. The increment is dropped, and the other byte keeps its value.
- R10: The two units are independent: running or writing one never changes the other.
- R11: In timer mode the count input has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntIn | input | 2 | Asynchronous count inputs, one per unit |
| regAddr | input | 3 | Register select for reads and writes |
| regWrEn | input | 1 | Write strobe, one byte per clock |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| irqAck | input | 2 | Interrupt acknowledge, one per unit |
| irqReq | output | 2 | Overflow interrupt requests, one per unit |

## Verification
The timer path is run for an exact whole number of machine cycles. This shows whether the divider counts twelve clocks, not eleven or thirteen, whatever its phase at the start. The same window is then repeated while the count input toggles fast, which separates a clean timer path from one that leaks the event path. The event path gets slow, well-held pulses, so a missed or doubly counted edge shows up as a wrong total. A byte write held across a counted falling edge tells write priority apart from a merged increment. Wraps on each unit, followed by an acknowledge in one case and a software clear in the other, separate the two ways a flag is cleared.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int UNITS = 2;
  localparam int BYTE_W = 8;
  localparam int CNT_W = 2 * BYTE_W;
  localparam int PRESCALE = 12;
  localparam int PS_W = $clog2(PRESCALE);
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;

  // strobes from control to datapath
  typedef struct packed {
    logic [UNITS-1:0] inc;
    logic [UNITS-1:0] wrLo;
    logic [UNITS-1:0] wrHi;
    logic [BYTE_W-1:0] data;
  } ptcStrobe_t;

  function automatic logic [ADDR_W-1:0] loAddr(input int u);
    return ADDR_W'(1 + 2 * u);
  endfunction

  function automatic logic [ADDR_W-1:0] hiAddr(input int u);
    return ADDR_W'(2 + 2 * u);
  endfunction

  function automatic int modeBit(input int u);
    return 2 + u;
  endfunction

  function automatic int runBit(input int u);
    return 4 + 2 * u;
  endfunction

  function automatic int flagBit(input int u);
    return 5 + 2 * u;
  endfunction
endpackage

// File: rtl/ptc_ctrl.sv
module ptc_ctrl
  import ptc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [UNITS-1:0]        cntIn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic                    regWrEn,
  input  logic [BYTE_W-1:0]       regWrData,
  input  logic [UNITS-1:0]        irqAck,
  input  logic [UNITS-1:0]        wrapHit,
  output ptcStrobe_t              strobe,
  output logic [BYTE_W-1:0]       ctrlByte,
  output logic [UNITS-1:0]        irqReq
);
  logic [PS_W-1:0] psCnt;
  logic            tick;
  logic            wrCtrl;
  logic [UNITS-1:0] incV, wrLoV, wrHiV, runV, modeV, flagV;

  // machine-cycle divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     psCnt <= '0;
    else if (tick) psCnt <= '0;
    else           psCnt <= psCnt + 1'b1;
  end
  assign tick   = (psCnt == PS_W'(PRESCALE - 1));
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [1:0] syncQ;
    logic       sampled;
    logic       fallSeen;
    logic       runR, modeR, flagR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        sampled <= 1'b0;
      end else begin
        syncQ <= {syncQ[0], cntIn[u]};
        if (tick) sampled <= syncQ[1];
      end
    end
    assign fallSeen = tick && sampled && !syncQ[1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runR  <= 1'b0;
        modeR <= 1'b0;
      end else if (wrCtrl) begin
        runR  <= regWrData[runBit(u)];
        modeR <= regWrData[modeBit(u)];
      end
    end

    // hardware set wins over acknowledge, acknowledge over software write
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           flagR <= 1'b0;
      else if (wrapHit[u]) flagR <= 1'b1;
      else if (irqAck[u])  flagR <= 1'b0;
      else if (wrCtrl)     flagR <= regWrData[flagBit(u)];
    end

    assign runV[u]  = runR;
    assign modeV[u] = modeR;
    assign flagV[u] = flagR;
    assign incV[u]  = runR && (modeR ? fallSeen : tick);
    assign wrLoV[u] = regWrEn && (regAddr == loAddr(u));
    assign wrHiV[u] = regWrEn && (regAddr == hiAddr(u));
  end

  always_comb begin
    ctrlByte = '0;
    for (int u = 0; u < UNITS; u++) begin
      ctrlByte[modeBit(u)] = modeV[u];
      ctrlByte[runBit(u)]  = runV[u];
      ctrlByte[flagBit(u)] = flagV[u];
    end
  end

  assign strobe.inc  = incV;
  assign strobe.wrLo = wrLoV;
  assign strobe.wrHi = wrHiV;
  assign strobe.data = regWrData;
  assign irqReq      = flagV;
endmodule

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  ptcStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [BYTE_W-1:0]             ctrlByte,
  output logic [UNITS-1:0][CNT_W-1:0]   cntVal,
  output logic [UNITS-1:0]              wrapHit,
  output logic [BYTE_W-1:0]             regRdData
);
  for (genvar u = 0; u < UNITS; u++) begin : g_cnt
    logic [CNT_W-1:0] cntR;
    logic             anyWr;

    assign anyWr = strobe.wrLo[u] || strobe.wrHi[u];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntR <= '0;
      end else if (anyWr) begin
        if (strobe.wrLo[u]) cntR[BYTE_W-1:0]     <= strobe.data;
        if (strobe.wrHi[u]) cntR[CNT_W-1:BYTE_W] <= strobe.data;
      end else if (strobe.inc[u]) begin
        cntR <= cntR + 1'b1;
      end
    end

    assign wrapHit[u] = strobe.inc[u] && !anyWr && (&cntR);
    assign cntVal[u]  = cntR;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) regRdData = ctrlByte;
    for (int u = 0; u < UNITS; u++) begin
      if (regAddr == loAddr(u)) regRdData = cntVal[u][BYTE_W-1:0];
      if (regAddr == hiAddr(u)) regRdData = cntVal[u][CNT_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/prescaled_timer_pair.sv
module prescaled_timer_pair
  import ptc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [UNITS-1:0]     cntIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [BYTE_W-1:0]    regWrData,
  output logic [BYTE_W-1:0]    regRdData,
  input  logic [UNITS-1:0]     irqAck,
  output logic [UNITS-1:0]     irqReq
);
  ptcStrobe_t                  strobe;
  logic [BYTE_W-1:0]           ctrlByte;
  logic [UNITS-1:0]            wrapHit;
  logic [UNITS-1:0][CNT_W-1:0] cntVal;

  ptc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntIn(cntIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .irqAck(irqAck),
    .wrapHit(wrapHit), .strobe(strobe), .ctrlByte(ctrlByte), .irqReq(irqReq)
  );

  ptc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .ctrlByte(ctrlByte), .cntVal(cntVal), .wrapHit(wrapHit),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic [7:0]  regWrData,
  input logic [1:0]  irqAck,
  input logic [1:0]  irqReq,
  input logic [1:0]  wrapHit,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1
);
  logic wr0, wr1;
  assign wr0 = regWrEn && (regAddr == 3'd1 || regAddr == 3'd2);
  assign wr1 = regWrEn && (regAddr == 3'd3 || regAddr == 3'd4);

  // R2: without a byte write a counter holds or steps by one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    !wr0 |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 16'd1));

  // R10: unit 1 likewise, untouched by unit 0 traffic
  a_r10_unit1_step: assert property (@(posedge clk) disable iff (!rstN)
    !wr1 |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + 16'd1));

  // R5: a wrap leaves zero and raises the request
  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit[0] |=> (irqReq[0] && cnt0 == 16'd0));

  // R6: acknowledge clears unless a wrap coincides
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck[0] && !wrapHit[0]) |=> !irqReq[0]);

  // R7: writing 0 to unit 1's flag bit clears it
  a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd0 && !regWrData[7] && !wrapHit[1]) |=> !irqReq[1]);

  // R9: a low-byte write always lands
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd1) |=> (cnt0[7:0] == $past(regWrData)));
endmodule

bind prescaled_timer_pair ptc_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .irqAck(irqAck), .irqReq(irqReq),
  .wrapHit(wrapHit), .cnt0(cntVal[0]), .cnt1(cntVal[1])
);

// File: tb/tb_prescaled_timer_pair.sv
`timescale 1ns/1ps
module tb_prescaled_timer_pair;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cntIn = 2'b11;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] irqAck = '0;
  logic [1:0] irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  localparam logic [2:0] A_CTRL = 3'd0, A_L0 = 3'd1, A_H0 = 3'd2, A_L1 = 3'd3, A_H1 = 3'd4;
  localparam logic [7:0] MODE0 = 8'h04, RUN0 = 8'h10, FLAG0 = 8'h20, RUN1 = 8'h40, FLAG1 = 8'h80;

  always #10 clk = ~clk;

  prescaled_timer_pair dut (
    .clk(clk), .rstN(rstN), .cntIn(cntIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqAck(irqAck), .irqReq(irqReq)
  );

  // monitor: pops expected items and compares the read port
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      testsRun++;
      if (regRdData !== it.exp) begin
        testsFailed++;
        $display("FAIL %s: read %h expected %h", it.req, regRdData, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string req);
    item_t it;
    regAddr = a;
    it.exp = e; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
    #2;
  endtask

  task automatic chkIrq(input logic [1:0] e, input string req);
    testsRun++;
    if (irqReq !== e) begin
      testsFailed++;
      $display("FAIL %s: irqReq %b expected %b", req, irqReq, e);
    end
  endtask

  // run for exactly n machine cycles, ctrl value v while running, s after
  task automatic runWindow(input int n, input logic [7:0] v, input logic [7:0] s, input bit toggle);
    wr(A_CTRL, v);
    for (int i = 0; i < 12 * n - 2; i++) begin
      @(negedge clk);
      if (toggle && (i % 5 == 0)) cntIn[0] = ~cntIn[0];
    end
    wr(A_CTRL, s);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) chk(3'(a), 8'h00, "R1 reset value");
    chkIrq(2'b00, "R1 reset irq");

    // R8 byte map and readback
    wr(A_L0, 8'hA5); wr(A_H0, 8'h3C); wr(A_L1, 8'h5A); wr(A_H1, 8'hC3);
    chk(A_L0, 8'hA5, "R8 unit0 low"); chk(A_H0, 8'h3C, "R8 unit0 high");
    chk(A_L1, 8'h5A, "R8 unit1 low"); chk(A_H1, 8'hC3, "R8 unit1 high");
    wr(A_CTRL, 8'h0C);
    chk(A_CTRL, 8'h0C, "R8 mode bits");
    wr(A_CTRL, 8'h00);
    wr(A_L0, 8'h00); wr(A_H0, 8'h00); wr(A_L1, 8'h00); wr(A_H1, 8'h00);

    // R2 timer: 5 machine cycles
    runWindow(5, RUN0, 8'h00, 1'b0);
    chk(A_L0, 8'h05, "R2 timer count");
    chk(A_H0, 8'h00, "R2 timer high byte");
    chk(A_L1, 8'h00, "R10 unit1 untouched");

    // R4 frozen with run clear: time and input edges
    for (int i = 0; i < 4; i++) begin
      cntIn[0] = 1'b0; repeat (30) @(negedge clk);
      cntIn[0] = 1'b1; repeat (30) @(negedge clk);
    end
    chk(A_L0, 8'h05, "R4 frozen count");

    // R3 event mode: three slow pulses
    wr(A_L0, 8'h00);
    wr(A_CTRL, MODE0 | RUN0);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      cntIn[0] = 1'b0; repeat (36) @(negedge clk);
      cntIn[0] = 1'b1; repeat (36) @(negedge clk);
    end
    wr(A_CTRL, MODE0);
    chk(A_L0, 8'h03, "R3 event count");
    chk(A_CTRL, MODE0, "R8 ctrl after stop");

    // R11 timer mode ignores fast input toggling
    wr(A_L0, 8'h00);
    runWindow(2, RUN0, 8'h00, 1'b1);
    chk(A_L0, 8'h02, "R11 timer ignores input");
    cntIn[0] = 1'b1;
    repeat (30) @(negedge clk);

    // R5 wrap on unit 0
    wr(A_L0, 8'hFE); wr(A_H0, 8'hFF);
    runWindow(2, RUN0, FLAG0, 1'b0);
    chk(A_L0, 8'h00, "R5 wrapped low");
    chk(A_H0, 8'h00, "R5 wrapped high");
    chk(A_CTRL, FLAG0, "R5 flag0 set");
    chkIrq(2'b01, "R5 irq0 raised");

    // R6 acknowledge clears
    @(negedge clk); irqAck = 2'b01;
    @(negedge clk); irqAck = 2'b00;
    chk(A_CTRL, 8'h00, "R6 flag0 cleared");
    chkIrq(2'b00, "R6 irq0 cleared");

    // R5 wrap on unit 1
    wr(A_L1, 8'hFF); wr(A_H1, 8'hFF);
    wr(A_CTRL, RUN1);
    for (int i = 0; i < 10; i++) @(negedge clk);
    wr(A_CTRL, FLAG1);
    chk(A_L1, 8'h00, "R5 unit1 wrapped");
    chk(A_CTRL, FLAG1, "R5 flag1 set");
    chkIrq(2'b10, "R5 irq1 raised");

    // R7 software clear
    wr(A_CTRL, 8'h00);
    chk(A_CTRL, 8'h00, "R7 flag1 cleared");
    chkIrq(2'b00, "R7 irq1 cleared");

    // R9 write beats increment on a counted edge
    wr(A_L0, 8'hFF); wr(A_H0, 8'h00);
    wr(A_CTRL, MODE0 | RUN0);
    repeat (30) @(negedge clk);
    @(negedge clk);
    regAddr = A_H0; regWrData = 8'h12; regWrEn = 1'b1; cntIn[0] = 1'b0;
    repeat (40) @(negedge clk);
    regWrEn = 1'b0;
    wr(A_CTRL, MODE0);
    chk(A_L0, 8'hFF, "R9 increment dropped");
    chk(A_H0, 8'h12, "R9 high byte written");
    chk(A_L1, 8'h00, "R10 unit1 still zero");
    chkIrq(2'b00, "R9 no wrap");

    finished = 1'b1;
    report();
  end
endmodule